// File: doc/BRIEF.md
# Two-stage watchdog timer

This block is a watchdog counter for a system-on-chip. While it runs, the counter steps down by one on each strobe of a slow tick. The tick is about one millisecond long, is derived from a 32 kHz clock and arrives already synchronised to the system clock. Software must write the kick register before the count runs out. A kick reloads the counter from the programmed load value.

In direct mode, running out of count raises a one-cycle reset request. In warning mode, the first run-out sets a sticky warning flag and can raise an interrupt. The counter then reloads itself for a second full period, and only the second run-out raises the reset request. Software clears the flag by writing a one to it. A stall enable, combined with a debug-cable-present input, freezes the count while a debugger is attached.

The load value can be changed only while the watchdog is stopped. To force a fast reset, software stops the watchdog, writes a load value of 2 and starts it again. All accesses are synchronous to the system clock, and reads are combinational from the read address.

Top module: `wdt_twostage`

## Requirements
- R1: After reset, every register reads 0, the counter reads 0, and `irq_o` and `rst_req_o` are low.
- R2: While running (CTRL bit0 = 1), each tick with more than 1 left lowers the count by one. While stopped, ticks leave the count unchanged.
- R3: A CTRL write that changes bit0 from 0 to 1 loads the counter from LOAD. Any write to address 2 (kick) reloads the counter from LOAD and returns the block to the first stage. Reading address 2 returns the count.
- R4: A write to LOAD (address 1) is ignored while CTRL bit0 = 1 and is taken while it is 0.
- R5: With CTRL bit2 = 0, a tick that finds the count at 1 or 0 raises `rst_req_o` for exactly one cycle, starting the cycle after the tick, and reloads the counter.
- R6: With CTRL bit2 = 1, the first run-out sets STAT bit0 (flag) and STAT bit1 (second stage) and reloads the counter, with no reset request. `irq_o` equals flag AND IEN bit0. STAT is at address 3 and IEN is at address 4.
- R7: A run-out while STAT bit1 = 1 raises the one-cycle reset request and clears STAT bit1.
- R8: Writing STAT with bit0 = 1 clears the flag, and writing bit0 = 0 leaves it unchanged. If a first-stage run-out occurs in the same cycle as the clear, the flag ends up set.
- R9: When CTRL bit1 = 1 and `dbg_cable_i` = 1, ticks do not change the count. Either condition alone does not stall the count.
- R10: A CTRL write that clears bit0 clears STAT bits 1 and 0, drops `irq_o` and freezes the count.
- R11: A kick in the same cycle as a run-out tick wins: no reset request is raised, the counter reloads, and the block returns to the first stage.
- R12: Stopping, writing LOAD = 2 and starting again raises the reset request on the second tick that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | Slow tick strobe, one system clock wide, already synchronised |
| dbg_cable_i | input | 1 | High while a debug cable is attached |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | AW (3) | Write address: 0 CTRL, 1 LOAD, 2 KICK, 3 STAT, 4 IEN |
| wr_data_i | input | DW (16) | Write data |
| rd_addr_i | input | AW (3) | Read address (address 2 reads the count) |
| rd_data_o | output | DW (16) | Read data, combinational |
| irq_o | output | 1 | Warning interrupt |
| rst_req_o | output | 1 | Reset request, one-cycle pulse |

## Verification
Two pairs of functions can fall in the same system-clock cycle. The first pair is a run-out tick and a software write to the block. The bench drives `tick_i` and the register write on the same falling edge so that both are sampled by one rising edge. It then judges the result after that edge at the ports. A flag clear that coincides with a first-stage run-out must leave STAT reading 3. A kick that coincides with a run-out must leave `rst_req_o` low, the counter reloaded and STAT bit1 clear.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned ADR_CTRL = 0;
  localparam int unsigned ADR_LOAD = 1;
  localparam int unsigned ADR_KICK = 2;
  localparam int unsigned ADR_STAT = 3;
  localparam int unsigned ADR_IEN  = 4;

  typedef struct packed {
    logic warn_mode;  // bit2
    logic stall_en;   // bit1
    logic run;        // bit0
  } ctrl_t;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned AW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          warn_evt_i,
  output ctrl_t         ctrl_o,
  output logic [DW-1:0] load_o,
  output logic          ien_o,
  output logic          flag_o,
  output logic          kick_o,
  output logic          start_o,
  output logic          stop_o
);
  ctrl_t         ctrl_q, ctrl_d;
  logic [DW-1:0] load_q, load_d;
  logic          ien_q, ien_d;
  logic          flag_q, flag_d;

  always_comb begin
    ctrl_d = ctrl_q;
    load_d = load_q;
    ien_d  = ien_q;
    flag_d = flag_q;
    kick_o = 1'b0;
    if (wr_en_i) begin
      case (wr_addr_i)
        AW'(ADR_CTRL): ctrl_d = ctrl_t'(wr_data_i[2:0]);
        AW'(ADR_LOAD): if (!ctrl_q.run) load_d = wr_data_i;
        AW'(ADR_KICK): kick_o = 1'b1;
        AW'(ADR_STAT): if (wr_data_i[0]) flag_d = 1'b0;
        AW'(ADR_IEN):  ien_d = wr_data_i[0];
        default: ;
      endcase
    end
    if (warn_evt_i) flag_d = 1'b1;  // set beats clear
    if (!ctrl_d.run) flag_d = 1'b0; // stopping drops the warning
  end

  assign start_o = ctrl_d.run & ~ctrl_q.run;
  assign stop_o  = ~ctrl_d.run & ctrl_q.run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      load_q <= '0;
      ien_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      load_q <= load_d;
      ien_q  <= ien_d;
      flag_q <= flag_d;
    end
  end

  assign ctrl_o = ctrl_q;
  assign load_o = load_q;
  assign ien_o  = ien_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/wdt_core.sv
module wdt_core #(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          dbg_cable_i,
  input  logic          run_i,
  input  logic          stall_en_i,
  input  logic          warn_mode_i,
  input  logic [DW-1:0] load_i,
  input  logic          kick_i,
  input  logic          start_i,
  input  logic          stop_i,
  output logic          warn_evt_o,
  output logic [DW-1:0] cnt_o,
  output logic          stage_o,
  output logic          rst_req_o
);
  logic [DW-1:0] cnt_q, cnt_d;
  logic          stage_q, stage_d;
  logic          rreq_q, rreq_d;
  logic          step_en;
  logic          last;

  assign step_en = tick_i & run_i & ~(stall_en_i & dbg_cable_i);
  assign last    = (cnt_q < DW'(2));

  always_comb begin
    cnt_d      = cnt_q;
    stage_d    = stage_q;
    rreq_d     = 1'b0;
    warn_evt_o = 1'b0;
    if (stop_i) begin
      stage_d = 1'b0;
    end else if (start_i || kick_i) begin
      cnt_d   = load_i;
      stage_d = 1'b0;
    end else if (step_en) begin
      if (!last) begin
        cnt_d = cnt_q - DW'(1);
      end else if (warn_mode_i && !stage_q) begin
        warn_evt_o = 1'b1;
        stage_d    = 1'b1;
        cnt_d      = load_i;
      end else begin
        rreq_d  = 1'b1;
        stage_d = 1'b0;
        cnt_d   = load_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      stage_q <= 1'b0;
      rreq_q  <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      stage_q <= stage_d;
      rreq_q  <= rreq_d;
    end
  end

  assign cnt_o     = cnt_q;
  assign stage_o   = stage_q;
  assign rst_req_o = rreq_q;
endmodule

// File: rtl/wdt_twostage.sv
module wdt_twostage
  import wdt_pkg::*;
#(
  parameter int unsigned DW        = 16,
  parameter int unsigned AW        = 3,
  parameter int unsigned SYNC_STGS = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          dbg_cable_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  output logic          irq_o,
  output logic          rst_req_o
);
  logic [SYNC_STGS-1:0] rs_q;
  logic                 rst_n_int;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rs_q <= '0;
    else         rs_q <= {rs_q[SYNC_STGS-2:0], 1'b1};
  end
  assign rst_n_int = rs_q[SYNC_STGS-1];

  ctrl_t         ctrl;
  logic [DW-1:0] load_q, cnt_q;
  logic          ien_q, flag_q, stage_q;
  logic          kick, start, stop, warn_evt;
  logic          run_s, stall_s;

  assign run_s   = ctrl.run;
  assign stall_s = ctrl.stall_en;

  wdt_regs #(.DW(DW), .AW(AW)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_int),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .warn_evt_i (warn_evt),
    .ctrl_o     (ctrl),
    .load_o     (load_q),
    .ien_o      (ien_q),
    .flag_o     (flag_q),
    .kick_o     (kick),
    .start_o    (start),
    .stop_o     (stop)
  );

  wdt_core #(.DW(DW)) u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_n_int),
    .tick_i      (tick_i),
    .dbg_cable_i (dbg_cable_i),
    .run_i       (ctrl.run),
    .stall_en_i  (ctrl.stall_en),
    .warn_mode_i (ctrl.warn_mode),
    .load_i      (load_q),
    .kick_i      (kick),
    .start_i     (start),
    .stop_i      (stop),
    .warn_evt_o  (warn_evt),
    .cnt_o       (cnt_q),
    .stage_o     (stage_q),
    .rst_req_o   (rst_req_o)
  );

  always_comb begin
    rd_data_o = '0;
    case (rd_addr_i)
      AW'(ADR_CTRL): rd_data_o = DW'(ctrl);
      AW'(ADR_LOAD): rd_data_o = load_q;
      AW'(ADR_KICK): rd_data_o = cnt_q;
      AW'(ADR_STAT): rd_data_o = DW'({stage_q, flag_q});
      AW'(ADR_IEN):  rd_data_o = DW'(ien_q);
      default: ;
    endcase
  end

  assign irq_o = flag_q & ien_q;
endmodule

// File: rtl/wdt_chk.sv
module wdt_chk #(
  parameter int unsigned DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          tick_i,
  input logic          dbg_cable_i,
  input logic          wr_en_i,
  input logic          irq_o,
  input logic          rst_req_o,
  input logic          run_s,
  input logic          stall_s,
  input logic [DW-1:0] cnt_q,
  input logic [DW-1:0] load_q,
  input logic          stage_q
);
  // R5: the reset request lasts one cycle when no further tick follows
  a_r5_one_cycle_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o && !tick_i |=> !rst_req_o);

  // R2: a stopped, untouched counter keeps its value
  a_r2_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_s && !wr_en_i |=> $stable(cnt_q));

  // R4: load value cannot move while running
  a_r4_load_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_s |=> $stable(load_q));

  // R9: stalled counter holds without writes
  a_r9_stall_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_s && stall_s && dbg_cable_i && !wr_en_i |=> $stable(cnt_q));

  // R10: stopped watchdog has no second stage and no interrupt
  a_r10_stopped_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_s |-> !stage_q && !irq_o);

  // R6: entering the second stage never comes with a reset request
  a_r6_warn_no_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stage_q) |-> !rst_req_o);

  // R7: a reset request leaves the first stage active
  a_r7_req_clears_stage: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> !stage_q);
endmodule

bind wdt_twostage wdt_chk #(.DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick_i      (tick_i),
  .dbg_cable_i (dbg_cable_i),
  .wr_en_i     (wr_en_i),
  .irq_o       (irq_o),
  .rst_req_o   (rst_req_o),
  .run_s       (run_s),
  .stall_s     (stall_s),
  .cnt_q       (cnt_q),
  .load_q      (load_q),
  .stage_q     (stage_q)
);

// File: tb/sim_wdt_twostage.sv
`timescale 1ns/1ps
module sim_wdt_twostage;
  localparam int DW = 16;
  localparam int AW = 3;
  localparam int VW = 2 + AW + DW + DW + 1;
  localparam int NV = 15;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0;
  logic          dbg = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic          irq, rreq;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  wdt_twostage u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .dbg_cable_i(dbg),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .irq_o(irq), .rst_req_o(rreq)
  );

  // op (0 write, 1 tick), addr, data, expected count, expected reset request
  localparam logic [VW-1:0] TBL [NV] = '{
    {2'd0, 3'd1, 16'd3, 16'd0, 1'b0},  // R4 load accepted while stopped
    {2'd0, 3'd0, 16'd1, 16'd3, 1'b0},  // R3 start loads count
    {2'd1, 3'd0, 16'd0, 16'd2, 1'b0},  // R2
    {2'd1, 3'd0, 16'd0, 16'd1, 1'b0},  // R2
    {2'd1, 3'd0, 16'd0, 16'd3, 1'b1},  // R5 direct run-out
    {2'd0, 3'd1, 16'd9, 16'd3, 1'b0},  // R5 pulse gone
    {2'd1, 3'd0, 16'd0, 16'd2, 1'b0},  // R2
    {2'd0, 3'd2, 16'd0, 16'd3, 1'b0},  // R3 kick
    {2'd1, 3'd0, 16'd0, 16'd2, 1'b0},  // R2
    {2'd0, 3'd0, 16'd0, 16'd2, 1'b0},  // R10 stop freezes
    {2'd1, 3'd0, 16'd0, 16'd2, 1'b0},  // R2 stopped ignores tick
    {2'd0, 3'd1, 16'd2, 16'd2, 1'b0},  // R12 load 2
    {2'd0, 3'd0, 16'd1, 16'd2, 1'b0},  // R12 restart
    {2'd1, 3'd0, 16'd0, 16'd1, 1'b0},  // R12
    {2'd1, 3'd0, 16'd0, 16'd2, 1'b1}   // R12 reset after second tick
  };

  task automatic chk(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d", req, got, exp);
    end
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] v);
    rd_addr = a;
    #0.5;
    v = rd_data;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tk();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic tk_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    tick = 1'b1; wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
  endtask

  initial begin
    #500000;
    bad++; total++;
    $display("FAIL watchdog timeout got=1 exp=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rd(AW'(a), v);
      chk("R1 register", v, '0);
    end
    chk("R1 irq", DW'(irq), 0);
    chk("R1 rst_req", DW'(rreq), 0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      if (TBL[i][VW-1 -: 2] == 2'd0)
        wr(TBL[i][VW-3 -: AW], TBL[i][DW+DW:DW+1]);
      else
        tk();
      rd(AW'(2), v);
      chk($sformatf("R2/R3/R5/R12 vec%0d count", i), v, TBL[i][DW:1]);
      chk($sformatf("R5/R12 vec%0d rst_req", i), DW'(rreq), DW'(TBL[i][0]));
    end

    // R4 lock while running
    wr(AW'(1), 16'd9);
    rd(AW'(1), v); chk("R4 load locked", v, 16'd2);

    // R6 and R7 warning mode
    wr(AW'(0), 16'd0);
    wr(AW'(4), 16'd1);
    wr(AW'(0), 16'd5);
    tk();
    tk();
    rd(AW'(3), v); chk("R6 status", v, 16'd3);
    chk("R6 irq", DW'(irq), 1);
    chk("R6 no rst_req", DW'(rreq), 0);
    rd(AW'(2), v); chk("R6 reload", v, 16'd2);
    tk();
    tk();
    chk("R7 rst_req", DW'(rreq), 1);
    rd(AW'(3), v); chk("R7 stage cleared", v, 16'd1);

    // R8 write-one-to-clear
    wr(AW'(3), 16'd0);
    rd(AW'(3), v); chk("R8 write 0 keeps", v, 16'd1);
    wr(AW'(3), 16'd1);
    rd(AW'(3), v); chk("R8 write 1 clears", v, 16'd0);
    chk("R8 irq low", DW'(irq), 0);
    tk();
    tk_wr(AW'(3), 16'd1);
    rd(AW'(3), v); chk("R8 set wins", v, 16'd3);

    // R11 kick beats run-out
    tk();
    tk_wr(AW'(2), 16'd0);
    chk("R11 no rst_req", DW'(rreq), 0);
    rd(AW'(2), v); chk("R11 reload", v, 16'd2);
    rd(AW'(3), v); chk("R11 first stage", v, 16'd1);

    // R9 debug stall
    wr(AW'(0), 16'd7);
    dbg = 1'b1;
    tk();
    rd(AW'(2), v); chk("R9 stalled", v, 16'd2);
    dbg = 1'b0;
    tk();
    rd(AW'(2), v); chk("R9 no cable", v, 16'd1);
    wr(AW'(2), 16'd0);
    wr(AW'(0), 16'd5);
    dbg = 1'b1;
    tk();
    rd(AW'(2), v); chk("R9 stall disabled", v, 16'd1);
    dbg = 1'b0;

    // R10 stop clears warning state
    tk();
    rd(AW'(3), v); chk("R10 pre status", v, 16'd3);
    wr(AW'(0), 16'd0);
    rd(AW'(3), v); chk("R10 status cleared", v, 16'd0);
    chk("R10 irq low", DW'(irq), 0);
    tk();
    rd(AW'(2), v); chk("R10 count frozen", v, 16'd2);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule